// File: doc/BRIEF.md
# Banked Address Translator

This block sits on the cartridge side of a console memory system. It keeps a file of sixteen byte-wide configuration registers and six pattern-bank registers. It snoops CPU write cycles in three address ranges and turns the upper bits of a CPU program address and a PPU pattern address into wide physical bank numbers. It also supplies a nametable mirroring select. The outputs are purely combinational from the stored registers, so a fetch sees a new mapping on the first cycle after the write that set it.

Each write is first classified into one of seven decode classes: `WR_IDLE` (no write or no match), `WR_CFG` (direct register file write), `WR_PPU_HI` and `WR_PPU_LO` (two single-address pattern-base loads), `WR_SEL` (target select), `WR_DATA` (indexed data write) and `WR_MIRR` (mirroring write). The class chosen in a cycle decides the register update at the next rising clock edge. No class persists across cycles, so there is no transition between classes: each write is classified on its own. A programmable inner mask decides which program-bank bits come from the per-window select registers and which come from a fill register. An outer base register supplies the high bank bits. Two program window modes and two window exchanges, one for program space and one for pattern space, are provided.

Top module: `mbx_mapper`

## Requirements
- R1: A write with address 0x4100..0x410F stores the data byte in configuration register addr[3:0]. Writes at 0x40FF or 0x4110 change nothing.
- R2: A write at exactly 0x2018 loads register 12 (pattern base high byte). A write at exactly 0x201A loads register 13 (control). Neighbouring addresses such as 0x2019 change nothing.
- R3: For writes in 0x8000..0xEFFF the class is chosen by addr & 0xE001. 0x8000 loads register 15, whose bits [2:0] name the data target. 0xA000 stores the inverse of data bit 0 into register 14. `mirror_sel` equals register 14 bit 0.
- R4: A data write (class 0x8001) with target 0..5 loads pattern register n with the data ANDed with a mask. The mask is 0x0F when register 13 bit 2 is set, and 0xFF shifted right by register 11 bits [7:4] otherwise.
- R5: A data write with target 6 or 7 uses the mask P = 0x3F >> register 11 bits [3:0]. It replaces only the P bits of register 7 (target 6) or register 8 (target 7) and keeps their other bits.
- R6: `prg_bank` = {register 0 bits [7:4], low byte}, where low = (inner & P) | (register 10 & ~P). `cpu_page` 0..3 selects windows 0x8000, 0xA000, 0xC000 and 0xE000. With register 13 bit 1 clear, the inner values are register 7, register 8, 0xFE and 0xFF.
- R7: With register 13 bit 1 set, windows 0..2 take their inner values from registers 7, 8 and 9, and window 3's low byte is register 10 unmasked.
- R8: When register 13 bit 0 and register 15 bit 6 are both set, pages 0 and 2 exchange their banks. If only one of the two bits is set, there is no exchange.
- R9: `chr_bank` = ((reg0[3:0]<<8 | reg12<<1 | reg13[7:3]) << 3) | v. For logical slots 0..3, v is pattern register 0 with bit 0 forced to 0, then 1, then pattern register 1 with bit 0 forced to 0, then 1. For slots 4..7, v is pattern registers 2..5. The logical slot is `ppu_page` with bit 2 inverted when register 15 bit 7 is set.
- R10: Reset clears every register to zero except register 9, which becomes 0x3E, and register 10, which becomes 0x3F.
- R11: Writes in 0x8000..0xEFFF that decode to 0xA001, 0xC000, 0xC001, 0xE000 or 0xE001, and writes at 0xF000 and above, change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all register updates on rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cpu_we | input | 1 | CPU write strobe |
| cpu_waddr | input | 16 | CPU write address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_page | input | 2 | CPU address bits [14:13] of the program fetch |
| ppu_page | input | 3 | PPU address bits [12:10] of the pattern fetch |
| prg_bank | output | 12 | 8 KB program bank number |
| chr_bank | output | 15 | 1 KB pattern bank number |
| mirror_sel | output | 1 | Nametable mirroring select |

## Verification
The bench targets these corner cases:
- Masked merge into the program select registers. A design that overwrote the whole byte would show wrong high bank bits once the mask narrows.
- Pattern mask chosen by control bit 2 versus the shifted mask. Getting it wrong leaks high data bits into `chr_bank`.
- Program-window exchange, which needs both enabling bits. A design keyed on one bit would swap pages 0 and 2 too early.
- The unmasked fourth window in the second mode, and the forced low bit on the 2 KB pattern pairs.
- Decode holes and neighbouring addresses. A loose decoder would corrupt registers there, which shows up as bank outputs drifting from the model.

// File: rtl/mbx_pkg.sv
`timescale 1ns/1ps
package mbx_pkg;
    localparam int DW      = 8;
    localparam int NCFG    = 16;
    localparam int NCHR    = 6;
    localparam int NSLOT   = 8;
    localparam int CIDX_W  = $clog2(NCFG);
    localparam int TGT_W   = 3;
    localparam int PRG_W   = 4 + DW;
    localparam int CHR_W   = 3 + 12;

    localparam int IX_OUTER = 0;
    localparam int IX_P0    = 7;
    localparam int IX_P1    = 8;
    localparam int IX_P2    = 9;
    localparam int IX_FILL  = 10;
    localparam int IX_MASK  = 11;
    localparam int IX_CHRHI = 12;
    localparam int IX_CTRL  = 13;
    localparam int IX_MIR   = 14;
    localparam int IX_SEL   = 15;

    typedef logic [DW-1:0] byte_t;

    typedef enum logic [2:0] {
        WR_IDLE,
        WR_CFG,
        WR_PPU_HI,
        WR_PPU_LO,
        WR_SEL,
        WR_DATA,
        WR_MIRR
    } wr_kind_e;
endpackage

// File: rtl/mbx_wr_decode.sv
`timescale 1ns/1ps
module mbx_wr_decode
    import mbx_pkg::*;
(
    input  logic        we_i,
    input  logic [15:0] addr_i,
    output wr_kind_e    kind_o
);
    always_comb begin
        kind_o = WR_IDLE;
        if (we_i) begin
            if (addr_i[15:4] == 12'h410) begin
                kind_o = WR_CFG;
            end else if (addr_i == 16'h2018) begin
                kind_o = WR_PPU_HI;
            end else if (addr_i == 16'h201A) begin
                kind_o = WR_PPU_LO;
            end else if (addr_i[15] && (addr_i[14:12] != 3'b111)) begin
                unique case ({addr_i[14:13], addr_i[0]})
                    3'b000:  kind_o = WR_SEL;
                    3'b001:  kind_o = WR_DATA;
                    3'b010:  kind_o = WR_MIRR;
                    default: kind_o = WR_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/mbx_cfg_regs.sv
`timescale 1ns/1ps
module mbx_cfg_regs
    import mbx_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  wr_kind_e               kind_i,
    input  logic [CIDX_W-1:0]      idx_i,
    input  byte_t                  data_i,
    output logic [NCFG-1:0][DW-1:0] cfg_o,
    output logic [NCHR-1:0][DW-1:0] chr_o
);
    logic [NCFG-1:0][DW-1:0] cfg_q;
    logic [NCHR-1:0][DW-1:0] chr_q;
    byte_t                   pmask;
    byte_t                   cmask;
    logic [TGT_W-1:0]        tgt;
    logic [CIDX_W-1:0]       pidx;

    assign tgt   = cfg_q[IX_SEL][TGT_W-1:0];
    assign pidx  = CIDX_W'(tgt) + CIDX_W'(1);
    assign pmask = 8'h3F >> cfg_q[IX_MASK][3:0];
    assign cmask = cfg_q[IX_CTRL][2] ? 8'h0F : (8'hFF >> cfg_q[IX_MASK][7:4]);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q          <= '0;
            cfg_q[IX_P2]   <= 8'h3E;
            cfg_q[IX_FILL] <= 8'h3F;
            chr_q          <= '0;
        end else begin
            unique case (kind_i)
                WR_CFG:    cfg_q[idx_i]    <= data_i;
                WR_PPU_HI: cfg_q[IX_CHRHI] <= data_i;
                WR_PPU_LO: cfg_q[IX_CTRL]  <= data_i;
                WR_SEL:    cfg_q[IX_SEL]   <= data_i;
                WR_MIRR:   cfg_q[IX_MIR]   <= {7'b0, ~data_i[0]};
                WR_DATA: begin
                    if (tgt < TGT_W'(NCHR)) begin
                        chr_q[tgt] <= data_i & cmask;
                    end else begin
                        cfg_q[pidx] <= (cfg_q[pidx] & ~pmask) | (data_i & pmask);
                    end
                end
                default: ;
            endcase
        end
    end

    assign cfg_o = cfg_q;
    assign chr_o = chr_q;

    // R10
    reset_vals_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (cfg_q[IX_P2] == 8'h3E && cfg_q[IX_FILL] == 8'h3F &&
                        cfg_q[IX_OUTER] == 8'h00 && cfg_q[IX_SEL] == 8'h00 && chr_q == '0));

    // R2
    ctrl_load_chk: assert property (@(posedge clk) disable iff (rst)
        (kind_i == WR_PPU_LO) |=> (cfg_q[IX_CTRL] == $past(data_i)));

    // R5
    prg_merge_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (kind_i == WR_DATA && tgt == 3'd6) |=>
        (((cfg_q[IX_P0] ^ $past(cfg_q[IX_P0])) & ~$past(pmask)) == 8'h00));

    // R4
    chr_nibble_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (kind_i == WR_DATA && tgt == 3'd0 && cfg_q[IX_CTRL][2]) |=> (chr_q[0][7:4] == 4'h0));

    // R11
    idle_no_change_chk: assert property (@(posedge clk) disable iff (rst)
        (kind_i == WR_IDLE) |=> ($stable(cfg_q) && $stable(chr_q)));
endmodule

// File: rtl/mbx_prg_xlat.sv
`timescale 1ns/1ps
module mbx_prg_xlat
    import mbx_pkg::*;
(
    input  logic [3:0]       outer_i,
    input  logic [3:0]       mshift_i,
    input  logic             mode_i,
    input  logic             swap_i,
    input  byte_t            p0_i,
    input  byte_t            p1_i,
    input  byte_t            p2_i,
    input  byte_t            fill_i,
    input  logic [1:0]       page_i,
    output logic [PRG_W-1:0] bank_o
);
    logic [1:0] lg;
    byte_t      pm;
    byte_t      inner;
    byte_t      low;

    assign pm = 8'h3F >> mshift_i;

    always_comb begin
        lg = page_i;
        if (swap_i && !page_i[0]) begin
            lg[1] = ~page_i[1];
        end
        unique case (lg)
            2'd0: inner = p0_i;
            2'd1: inner = p1_i;
            2'd2: inner = mode_i ? p2_i : 8'hFE;
            2'd3: inner = 8'hFF;
        endcase
        low = (inner & pm) | (fill_i & ~pm);
        if (mode_i && (lg == 2'd3)) begin
            low = fill_i;
        end
        bank_o = {outer_i, low};
    end
endmodule

// File: rtl/mbx_chr_xlat.sv
`timescale 1ns/1ps
module mbx_chr_xlat
    import mbx_pkg::*;
(
    input  logic [3:0]              outer_i,
    input  byte_t                   hi_i,
    input  logic [4:0]              lo_i,
    input  logic                    inv_i,
    input  logic [NCHR-1:0][DW-1:0] chr_i,
    input  logic [2:0]              page_i,
    output logic [CHR_W-1:0]        bank_o
);
    byte_t       slot_val [NSLOT];
    logic [2:0]  lg;
    logic [11:0] base;

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        if (s < 4) begin : g_pair
            if (s % 2 == 0) begin : g_even
                assign slot_val[s] = chr_i[s/2] & 8'hFE;
            end else begin : g_odd
                assign slot_val[s] = chr_i[s/2] | 8'h01;
            end
        end else begin : g_single
            assign slot_val[s] = chr_i[s-2];
        end
    end

    assign lg     = page_i ^ {inv_i, 2'b00};
    assign base   = {outer_i, 8'h00} | {3'b000, hi_i, 1'b0} | {7'b0, lo_i};
    assign bank_o = {base, 3'b000} | {7'b0, slot_val[lg]};
endmodule

// File: rtl/mbx_mapper.sv
`timescale 1ns/1ps
module mbx_mapper
    import mbx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_we,
    input  logic [15:0]       cpu_waddr,
    input  logic [7:0]        cpu_wdata,
    input  logic [1:0]        cpu_page,
    input  logic [2:0]        ppu_page,
    output logic [PRG_W-1:0]  prg_bank,
    output logic [CHR_W-1:0]  chr_bank,
    output logic              mirror_sel
);
    wr_kind_e                kind;
    logic [NCFG-1:0][DW-1:0] cfg;
    logic [NCHR-1:0][DW-1:0] chr;
    logic                    unused_cfg_bits;

    mbx_wr_decode u_dec (
        .we_i   (cpu_we),
        .addr_i (cpu_waddr),
        .kind_o (kind)
    );

    mbx_cfg_regs u_regs (
        .clk    (clk),
        .rst    (rst),
        .kind_i (kind),
        .idx_i  (cpu_waddr[CIDX_W-1:0]),
        .data_i (cpu_wdata),
        .cfg_o  (cfg),
        .chr_o  (chr)
    );

    mbx_prg_xlat u_prg (
        .outer_i  (cfg[IX_OUTER][7:4]),
        .mshift_i (cfg[IX_MASK][3:0]),
        .mode_i   (cfg[IX_CTRL][1]),
        .swap_i   (cfg[IX_CTRL][0] & cfg[IX_SEL][6]),
        .p0_i     (cfg[IX_P0]),
        .p1_i     (cfg[IX_P1]),
        .p2_i     (cfg[IX_P2]),
        .fill_i   (cfg[IX_FILL]),
        .page_i   (cpu_page),
        .bank_o   (prg_bank)
    );

    mbx_chr_xlat u_chr (
        .outer_i (cfg[IX_OUTER][3:0]),
        .hi_i    (cfg[IX_CHRHI]),
        .lo_i    (cfg[IX_CTRL][7:3]),
        .inv_i   (cfg[IX_SEL][7]),
        .chr_i   (chr),
        .page_i  (ppu_page),
        .bank_o  (chr_bank)
    );

    assign mirror_sel = cfg[IX_MIR][0];

    assign unused_cfg_bits = ^{cfg[6:1], cfg[IX_MASK][7:4], cfg[IX_CTRL][2],
                               cfg[IX_MIR][7:1], cfg[IX_SEL][5:0]};

    // R3
    mirror_invert_chk: assert property (@(posedge clk) disable iff (rst)
        (kind == WR_MIRR) |=> (mirror_sel == ~$past(cpu_wdata[0])));
endmodule

// File: tb/tb_mbx_mapper.sv
`timescale 1ns/1ps
module tb_mbx_mapper;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_we = 1'b0;
    logic [15:0] cpu_waddr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic [1:0]  cpu_page = '0;
    logic [2:0]  ppu_page = '0;
    logic [11:0] prg_bank;
    logic [14:0] chr_bank;
    logic        mirror_sel;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int mr [16];
    int mc [6];

    always #5 clk = ~clk;

    mbx_mapper dut (
        .clk(clk), .rst(rst), .cpu_we(cpu_we), .cpu_waddr(cpu_waddr),
        .cpu_wdata(cpu_wdata), .cpu_page(cpu_page), .ppu_page(ppu_page),
        .prg_bank(prg_bank), .chr_bank(chr_bank), .mirror_sel(mirror_sel)
    );

    task automatic m_reset();
        foreach (mr[i]) mr[i] = 0;
        foreach (mc[i]) mc[i] = 0;
        mr[9]  = 'h3E;
        mr[10] = 'h3F;
    endtask

    task automatic m_write(input int a, input int d);
        int t;
        int m;
        if (a >= 'h4100 && a <= 'h410F) mr[a % 16] = d;
        else if (a == 'h2018) mr[12] = d;
        else if (a == 'h201A) mr[13] = d;
        else if (a >= 'h8000 && a <= 'hEFFF) begin
            case (a & 'hE001)
                'h8000: mr[15] = d;
                'hA000: mr[14] = (d % 2 == 1) ? 0 : 1;
                'h8001: begin
                    t = mr[15] % 8;
                    if (t < 6) begin
                        m = ((mr[13] / 4) % 2 == 1) ? 'h0F : ('hFF >> (mr[11] / 16));
                        mc[t] = d & m;
                    end else begin
                        m = 'h3F >> (mr[11] % 16);
                        mr[t+1] = (mr[t+1] & ~m) | (d & m);
                    end
                end
                default: ;
            endcase
        end
    endtask

    function automatic int exp_prg(input int page);
        int pm, lg, inner, low;
        pm = 'h3F >> (mr[11] % 16);
        lg = page;
        if ((mr[13] % 2 == 1) && ((mr[15] / 64) % 2 == 1) && (page == 0 || page == 2))
            lg = 2 - page;
        case (lg)
            0: inner = mr[7];
            1: inner = mr[8];
            2: inner = ((mr[13] / 2) % 2 == 1) ? mr[9] : 'hFE;
            default: inner = 'hFF;
        endcase
        low = ((inner & pm) | (mr[10] & ~pm)) & 'hFF;
        if (lg == 3 && ((mr[13] / 2) % 2 == 1)) low = mr[10];
        return ((mr[0] / 16) * 256) + low;
    endfunction

    function automatic int exp_chr(input int s);
        int lg, v, base;
        lg = (mr[15] >= 128) ? (s ^ 4) : s;
        case (lg)
            0: v = mc[0] & 'hFE;
            1: v = mc[0] | 1;
            2: v = mc[1] & 'hFE;
            3: v = mc[1] | 1;
            default: v = mc[lg-2];
        endcase
        base = ((mr[0] % 16) * 256) | (mr[12] * 2) | (mr[13] / 8);
        return (base * 8) | v;
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        for (int p = 0; p < 4; p++) begin
            cpu_page = 2'(p);
            #0.5;
            chk(tag, $sformatf("prg page %0d", p), int'(prg_bank), exp_prg(p));
        end
        for (int s = 0; s < 8; s++) begin
            ppu_page = 3'(s);
            #0.5;
            chk(tag, $sformatf("chr slot %0d", s), int'(chr_bank), exp_chr(s));
        end
        chk(tag, "mirror", int'(mirror_sel), mr[14] % 2);
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_waddr = a;
        cpu_wdata = d;
        cpu_we    = 1'b1;
        @(negedge clk);
        cpu_we    = 1'b0;
        m_write(int'(a), int'(d));
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        m_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R10 reset state
        check_all("R10");

        // R1 register file window and its edges
        wr(16'h4100, 8'h52);
        wr(16'h410C, 8'h11);
        check_all("R1");
        wr(16'h4110, 8'hFF);
        wr(16'h40FF, 8'hFF);
        check_all("R1");

        // R2 single-address loads
        wr(16'h2018, 8'h81);
        wr(16'h201A, 8'hA8);
        wr(16'h2019, 8'hFF);
        check_all("R2");

        // R3 select and mirroring
        wr(16'hA000, 8'h00);
        check_all("R3");
        wr(16'hA000, 8'h01);
        check_all("R3");
        wr(16'hBFFE, 8'h02);
        check_all("R3");

        // R4 pattern registers under the three masks
        for (int t = 0; t < 6; t++) begin
            wr(16'h8000, 8'(t));
            wr(16'h8001, 8'(8'hC3 + t * 16));
        end
        check_all("R4");
        wr(16'h410B, 8'h20);
        wr(16'h8000, 8'h02);
        wr(16'h8001, 8'hFF);
        check_all("R4");
        wr(16'h201A, 8'h04);
        wr(16'h8000, 8'h04);
        wr(16'h8001, 8'hB7);
        check_all("R4");

        // R5 masked merge into program selects
        wr(16'h410B, 8'h02);
        wr(16'h4107, 8'hF0);
        wr(16'h8000, 8'h06);
        wr(16'h8001, 8'hAB);
        check_all("R5");
        wr(16'h8000, 8'h07);
        wr(16'h8001, 8'h3C);
        check_all("R5");

        // R6 first mode with varied masks
        wr(16'h201A, 8'h00);
        wr(16'h410A, 8'h9A);
        for (int k = 0; k < 7; k++) begin
            wr(16'h410B, 8'(k));
            check_all("R6");
        end

        // R7 second mode
        wr(16'h201A, 8'h02);
        wr(16'h4109, 8'h27);
        check_all("R7");
        wr(16'h410B, 8'h00);
        check_all("R7");

        // R8 exchange needs both bits
        wr(16'h8000, 8'h40);
        check_all("R8");
        wr(16'h201A, 8'h03);
        check_all("R8");
        wr(16'h8000, 8'h00);
        check_all("R8");

        // R9 pattern composition and inversion
        wr(16'h4100, 8'h07);
        wr(16'h2018, 8'hFF);
        wr(16'h201A, 8'hF8);
        check_all("R9");
        wr(16'h8000, 8'h80);
        check_all("R9");

        // R11 decode holes and top range
        wr(16'hA001, 8'h00);
        wr(16'hC000, 8'h55);
        wr(16'hC001, 8'h55);
        wr(16'hE000, 8'h55);
        wr(16'hE001, 8'h55);
        wr(16'hF000, 8'h55);
        wr(16'hF001, 8'h55);
        check_all("R11");

        // R6 mixed traffic
        for (int n = 0; n < 300; n++) begin
            logic [15:0] a;
            case ($urandom_range(0, 6))
                0: a = 16'h4100 | 16'($urandom_range(0, 15));
                1: a = 16'h2018;
                2: a = 16'h201A;
                3: a = 16'h8000 | 16'($urandom_range(0, 15) * 2);
                4: a = 16'h8001 | 16'($urandom_range(0, 255) * 2);
                5: a = 16'hA000;
                default: a = 16'($urandom_range(0, 65535));
            endcase
            wr(a, 8'($urandom_range(0, 255)));
            check_all("R6");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule